// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This block transfers blocks of words between an 8-bit external byte memory and on-chip program or data memory. On a load it reads successive bytes and assembles them into 24-, 16- or 8-bit words, then writes each word into on-chip memory. On a store it reads on-chip words and writes them out as a sequence of bytes. The external byte address is 22 bits wide: an 8-bit page on top of a 14-bit in-page offset. The address counts across page boundaries.

Software sets up the transfer through a small write-only register port: a control word, the start page, the in-page offset, the on-chip start address, and a word count. A nonzero count write starts the engine. The count stays visible while it runs down. Every byte access lasts a programmable number of wait states. Any external access by the core takes priority over the engine's next byte access. A one-cycle interrupt marks completion. The engine can also hold the core for the whole transfer and then request a context reset, so that execution restarts at address 0.

Top module: `bytemem_dma`

## Requirements
- R1: Register writes use `reg_sel` as follows: 0 control, 1 page, 2 in-page offset, 3 on-chip address, 4 count. The control word is laid out as [1:0] format, [2] direction, [3] halt, [7:4] wait states and [11:8] overlay. Writing a nonzero count while idle starts the transfer. Writing zero starts nothing. After reset the block is idle with count 0.
- R2: `bm_addr` is {page, offset} and advances by one after every byte access. The carry from the offset passes into the page.
- R3: Format 00 moves 24-bit words to or from program memory (`mem_pm`=1), most significant byte first.
- R4: Format 01 moves 16-bit words to or from data memory, high byte first. Bits 23:16 of the word are zero.
- R5: Format 10 places one byte in bits 15:8 of a data-memory word. Format 11 places it in bits 7:0. All other bits are zero.
- R6: With direction 1, each on-chip word is read once and written out as bytes, most significant byte first. The bytes are [23:16],[15:8],[7:0] for format 00, [15:8],[7:0] for format 01, [15:8] for format 10 and [7:0] for format 11. With direction 0, data moves from byte memory into on-chip memory.
- R7: `cnt_o` decreases by one per completed word. When it reaches zero the transfer ends and `done_irq` is high for exactly one cycle.
- R8: Each byte access holds `bm_req` high for the programmed wait-state count plus one cycles.
- R9: A byte access never begins in a cycle that follows a cycle with `core_ext_req` high.
- R10: Each word takes exactly one on-chip handshake (`mem_req` with `mem_gnt`). `mem_req` and `bm_req` are never high together.
- R11: With the halt bit set, `core_halt` is high for the whole transfer and `ctx_reset` pulses together with `done_irq`. With the halt bit clear, both stay low.
- R12: All register writes are ignored while the engine is busy, including page, offset and count.
- R13: `mem_ovl` presents the overlay field of the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 14 | Register write data |
| cnt_o | output | 14 | Live remaining word count |
| busy_o | output | 1 | Transfer in progress |
| bm_addr | output | 22 | Byte memory address {page, offset} |
| bm_req | output | 1 | Byte access active |
| bm_we | output | 1 | Byte access is a write |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| core_ext_req | input | 1 | Core external-memory request (priority) |
| mem_req | output | 1 | On-chip memory request |
| mem_gnt | input | 1 | On-chip memory grant |
| mem_we | output | 1 | On-chip write (load direction) |
| mem_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr | output | 14 | On-chip word address |
| mem_wdata | output | 24 | On-chip write word |
| mem_rdata | input | 24 | On-chip read word |
| mem_ovl | output | 4 | Overlay bits passed through |
| done_irq | output | 1 | Completion pulse |
| core_halt | output | 1 | Hold request to the core |
| ctx_reset | output | 1 | Context-reset request at completion |

## Verification
A wrong byte index or a stale shift register shows up as a misplaced or shifted byte. This is visible at the first word written to on-chip memory, or at the first byte written on a store. A wrong wait counter or a broken arbitration path changes the length or start of a `bm_req` pulse in that same access. A count or address register that misses a step shows up at the end of the transfer: the interrupt comes early or late, or `bm_addr` ends away from start plus bytes moved. The live count is also compared against the words already written, so a count error appears at the next word.

// File: rtl/bmdma_pkg.sv
// Shared types, register selects and word packing helpers for the byte DMA.
// Assumes byte memory is 8 bits wide and on-chip words at most 24 bits.
package bmdma_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM,
        ST_BWAIT,
        ST_BACC,
        ST_DONE
    } st_e;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_PAGE = 3'd1;
    localparam logic [2:0] SEL_OFS  = 3'd2;
    localparam logic [2:0] SEL_IADR = 3'd3;
    localparam logic [2:0] SEL_CNT  = 3'd4;

    localparam logic [1:0] FMT_PM24  = 2'b00;
    localparam logic [1:0] FMT_DM16  = 2'b01;
    localparam logic [1:0] FMT_DM8HI = 2'b10;
    localparam logic [1:0] FMT_DM8LO = 2'b11;

    // Number of byte accesses per word for a format.
    function automatic logic [1:0] bytes_per_word(input logic [1:0] fmt);
        case (fmt)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // Build the on-chip word from bytes shifted in (last byte in [7:0]).
    function automatic logic [WORD_W-1:0] pack_word(input logic [1:0] fmt,
                                                    input logic [WORD_W-1:0] acc);
        case (fmt)
            FMT_PM24:  return acc;
            FMT_DM16:  return {8'h00, acc[15:0]};
            FMT_DM8HI: return {8'h00, acc[7:0], 8'h00};
            default:   return {16'h0000, acc[7:0]};
        endcase
    endfunction

    // Align an on-chip word so its first outgoing byte sits in [23:16].
    function automatic logic [WORD_W-1:0] unpack_word(input logic [1:0] fmt,
                                                      input logic [WORD_W-1:0] w);
        case (fmt)
            FMT_PM24:  return w;
            FMT_DM16:  return {w[15:0], 8'h00};
            FMT_DM8HI: return {w[15:8], 16'h0000};
            default:   return {w[7:0], 16'h0000};
        endcase
    endfunction

endpackage

// File: rtl/bmdma_regs.sv
// Configuration and address/count registers of the byte DMA.
// Accepts writes only while idle. The sequencer steps the address and
// count registers through single-cycle increment/decrement strobes.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int OFS_W   = 14,
    parameter int IADR_W  = 14,
    parameter int CNT_W   = 14,
    parameter int WS_W    = 4,
    parameter int OVL_W   = 4,
    parameter int XA_W    = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              busy,
    input  logic              ext_inc,
    input  logic              int_inc,
    input  logic              cnt_dec,
    output logic [1:0]        fmt,
    output logic              dir,
    output logic              halt,
    output logic [WS_W-1:0]   waits,
    output logic [OVL_W-1:0]  ovl,
    output logic [XA_W-1:0]   xaddr,
    output logic [IADR_W-1:0] iaddr,
    output logic [CNT_W-1:0]  cnt,
    output logic              start
);
    localparam int WS_LSB  = 4;
    localparam int OVL_LSB = WS_LSB + WS_W;

    logic wr_ok;
    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (sel == SEL_CNT) && (wdata != '0);

    // Control fields: format, direction, halt, wait states, overlay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt   <= FMT_PM24;
            dir   <= 1'b0;
            halt  <= 1'b0;
            waits <= '0;
            ovl   <= '0;
        end else if (wr_ok && sel == SEL_CTRL) begin
            fmt   <= wdata[1:0];
            dir   <= wdata[2];
            halt  <= wdata[3];
            waits <= wdata[WS_LSB +: WS_W];
            ovl   <= wdata[OVL_LSB +: OVL_W];
        end
    end

    // External byte address: page and offset writes, per-byte increment with carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xaddr <= '0;
        end else if (wr_ok && sel == SEL_PAGE) begin
            xaddr[XA_W-1 -: PAGE_W] <= wdata[PAGE_W-1:0];
        end else if (wr_ok && sel == SEL_OFS) begin
            xaddr[OFS_W-1:0] <= wdata[OFS_W-1:0];
        end else if (ext_inc) begin
            xaddr <= xaddr + 1'b1;
        end
    end

    // On-chip word address: write or per-word increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iaddr <= '0;
        end else if (wr_ok && sel == SEL_IADR) begin
            iaddr <= wdata[IADR_W-1:0];
        end else if (int_inc) begin
            iaddr <= iaddr + 1'b1;
        end
    end

    // Live word count: loaded by a starting write, decremented per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= wdata;
        end else if (cnt_dec) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/bmdma_seq.sv
// Transfer sequencer: steps through byte accesses with wait states, yields
// to core external requests before each byte, and performs one on-chip
// handshake per word. A single shift register assembles bytes on loads
// and serialises words on stores. Assumes configuration is stable while busy.
module bmdma_seq
    import bmdma_pkg::*;
#(
    parameter int WS_W  = 4,
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [1:0]        fmt,
    input  logic [WS_W-1:0]   waits,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              core_ext_req,
    input  logic [BYTE_W-1:0] bm_rdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              bm_req,
    output logic              bm_we,
    output logic [BYTE_W-1:0] bm_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ext_inc,
    output logic              int_inc,
    output logic              cnt_dec,
    output logic              done
);
    st_e               st;
    logic [WS_W-1:0]   wcnt;
    logic [1:0]        bidx;
    logic [WORD_W-1:0] shreg;
    logic              byte_end, last_byte, cnt_last;

    assign byte_end  = (st == ST_BACC) && (wcnt == '0);
    assign last_byte = (bidx == bytes_per_word(fmt) - 2'd1);
    assign cnt_last  = (cnt == CNT_W'(1));

    assign busy      = (st != ST_IDLE);
    assign bm_req    = (st == ST_BACC);
    assign bm_we     = bm_req && dir;
    assign bm_wdata  = shreg[WORD_W-1 -: BYTE_W];
    assign mem_req   = (st == ST_MEM);
    assign mem_we    = !dir;
    assign mem_wdata = pack_word(fmt, shreg);
    assign ext_inc   = byte_end;
    assign int_inc   = mem_req && mem_gnt;
    assign cnt_dec   = (int_inc && !dir) || (byte_end && last_byte && dir);
    assign done      = (st == ST_DONE);

    // Main transfer state machine with wait counter, byte index and shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            wcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= dir ? ST_MEM : ST_BWAIT;
                        bidx <= '0;
                    end
                end
                ST_BWAIT: begin
                    if (!core_ext_req) begin
                        st   <= ST_BACC;
                        wcnt <= waits;
                    end
                end
                ST_BACC: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - 1'b1;
                    end else begin
                        shreg <= dir ? {shreg[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}}
                                     : {shreg[WORD_W-BYTE_W-1:0], bm_rdata};
                        if (last_byte) begin
                            bidx <= '0;
                            if (!dir)          st <= ST_MEM;
                            else if (cnt_last) st <= ST_DONE;
                            else               st <= ST_MEM;
                        end else begin
                            bidx <= bidx + 1'b1;
                            st   <= ST_BWAIT;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_gnt) begin
                        if (dir) begin
                            shreg <= unpack_word(fmt, mem_rdata);
                            st    <= ST_BWAIT;
                        end else begin
                            st <= cnt_last ? ST_DONE : ST_BWAIT;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bytemem_dma.sv
// Top of the byte-wide memory DMA engine: register block plus sequencer.
// Passes overlay bits through and derives core hold and context-reset
// requests from the halt bit. Assumes a synchronous active-low reset.
module bytemem_dma
    import bmdma_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 14,
    parameter int IADR_W = 14,
    parameter int CNT_W  = 14,
    parameter int WS_W   = 4,
    parameter int OVL_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [2:0]                reg_sel,
    input  logic [CNT_W-1:0]          reg_wdata,
    output logic [CNT_W-1:0]          cnt_o,
    output logic                      busy_o,
    output logic [PAGE_W+OFS_W-1:0]   bm_addr,
    output logic                      bm_req,
    output logic                      bm_we,
    output logic [BYTE_W-1:0]         bm_wdata,
    input  logic [BYTE_W-1:0]         bm_rdata,
    input  logic                      core_ext_req,
    output logic                      mem_req,
    input  logic                      mem_gnt,
    output logic                      mem_we,
    output logic                      mem_pm,
    output logic [IADR_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic [OVL_W-1:0]          mem_ovl,
    output logic                      done_irq,
    output logic                      core_halt,
    output logic                      ctx_reset
);
    localparam int XA_W = PAGE_W + OFS_W;

    logic [1:0]      fmt;
    logic            dir, halt, start, busy, done;
    logic            ext_inc, int_inc, cnt_dec;
    logic [WS_W-1:0] waits;

    bmdma_regs #(
        .PAGE_W(PAGE_W), .OFS_W(OFS_W), .IADR_W(IADR_W), .CNT_W(CNT_W),
        .WS_W(WS_W), .OVL_W(OVL_W), .XA_W(XA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .busy(busy), .ext_inc(ext_inc), .int_inc(int_inc), .cnt_dec(cnt_dec),
        .fmt(fmt), .dir(dir), .halt(halt), .waits(waits), .ovl(mem_ovl),
        .xaddr(bm_addr), .iaddr(mem_addr), .cnt(cnt_o), .start(start)
    );

    bmdma_seq #(.WS_W(WS_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .fmt(fmt),
        .waits(waits), .cnt(cnt_o), .core_ext_req(core_ext_req),
        .bm_rdata(bm_rdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .bm_req(bm_req), .bm_we(bm_we), .bm_wdata(bm_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .ext_inc(ext_inc), .int_inc(int_inc), .cnt_dec(cnt_dec), .done(done)
    );

    assign busy_o    = busy;
    assign mem_pm    = (fmt == FMT_PM24);
    assign done_irq  = done;
    assign core_halt = busy && halt;
    assign ctx_reset = done && halt;
endmodule

// File: rtl/bytemem_dma_chk.sv
// Protocol checker for the byte DMA, bound to the top module.
// Observes only top-level ports; assumes synchronous active-low reset.
module bytemem_dma_chk #(
    parameter int CNT_W = 14,
    parameter int XA_W  = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [XA_W-1:0]  bm_addr,
    input logic             bm_req,
    input logic             core_ext_req,
    input logic             mem_req,
    input logic             done_irq,
    input logic             ctx_reset
);
    // Completion pulse lasts one cycle.
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // While running, the count only ever steps down by one.
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(cnt_o)) |-> (cnt_o == $past(cnt_o) - 1'b1));

    // A byte access begins only after a cycle free of core requests.
    assert_core_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_req) |-> !$past(core_ext_req));

    // The two memory sides are never requested together.
    assert_one_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && bm_req));

    // Each finished byte access advances the external address by one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $fell(bm_req)) |-> (bm_addr == $past(bm_addr) + 1'b1));

    // Context reset only comes with completion.
    assert_ctx_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_reset |-> done_irq);

    // Idle engine issues no requests.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bm_req && !mem_req));
endmodule

bind bytemem_dma bytemem_dma_chk #(.CNT_W(CNT_W), .XA_W(PAGE_W + OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .cnt_o(cnt_o), .bm_addr(bm_addr),
    .bm_req(bm_req), .core_ext_req(core_ext_req), .mem_req(mem_req),
    .done_irq(done_irq), .ctx_reset(ctx_reset)
);

// File: tb/bytemem_dma_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random transfers.
module bytemem_dma_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, reg_wr, busy_o, bm_req, bm_we, core_ext_req, mem_req, mem_gnt;
    logic        mem_we, mem_pm, done_irq, core_halt, ctx_reset;
    logic [2:0]  reg_sel;
    logic [13:0] reg_wdata, cnt_o, mem_addr;
    logic [21:0] bm_addr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic [23:0] mem_wdata, mem_rdata;
    logic [3:0]  mem_ovl;

    bytemem_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cnt_o(cnt_o), .busy_o(busy_o), .bm_addr(bm_addr), .bm_req(bm_req), .bm_we(bm_we),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .core_ext_req(core_ext_req),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_pm(mem_pm),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ovl(mem_ovl), .done_irq(done_irq), .core_halt(core_halt), .ctx_reset(ctx_reset)
    );

    // Byte memory and on-chip memory contents as functions of address.
    function automatic logic [7:0] bfun(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
    endfunction
    function automatic logic [23:0] gfun(input logic [13:0] a, input logic pm);
        if (pm) return {a[7:0] ^ 8'hC3, ~a[7:0], a[13:6]};
        return {8'hEE, a[7:0] ^ 8'h3C, a[13:6] ^ 8'h81};
    endfunction
    function automatic int nbytes(input logic [1:0] f);
        return (f == 2'b00) ? 3 : (f == 2'b01) ? 2 : 1;
    endfunction
    // Expected on-chip word for a load starting at byte address a.
    function automatic logic [23:0] exp_load(input logic [1:0] f, input logic [21:0] a);
        logic [7:0] b0, b1, b2;
        b0 = bfun(a); b1 = bfun(a + 22'd1); b2 = bfun(a + 22'd2);
        case (f)
            2'b00:   return {b0, b1, b2};
            2'b01:   return {8'h00, b0, b1};
            2'b10:   return {8'h00, b0, 8'h00};
            default: return {16'h0000, b0};
        endcase
    endfunction
    // Expected j-th outgoing byte of a store word.
    function automatic logic [7:0] exp_store(input logic [1:0] f, input logic [23:0] w, input int j);
        case (f)
            2'b00:   return (j == 0) ? w[23:16] : (j == 1) ? w[15:8] : w[7:0];
            2'b01:   return (j == 0) ? w[15:8] : w[7:0];
            2'b10:   return w[15:8];
            default: return w[7:0];
        endcase
    endfunction
    function automatic string ftag(input logic [1:0] f);
        return (f == 2'b00) ? "R3" : (f == 2'b01) ? "R4" : "R5";
    endfunction

    assign bm_rdata  = bfun(bm_addr);
    assign mem_rdata = gfun(mem_addr, mem_pm);

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor state
    bit mon_on = 0, ext_noise = 0, gnt_noise = 0, prev_bm = 0, cur_halt = 0;
    int run = 0, words_seen = 0, grants = 0, irqs = 0, ctxs = 0, cur_waits = 0, cur_n = 0;
    logic [23:0] pm_wr [int];
    logic [23:0] dm_wr [int];
    logic [7:0]  bwr   [int];

    initial begin mem_gnt = 1'b0; core_ext_req = 1'b0; end

    // Per-cycle observer and driver of grant and core requests.
    always @(negedge clk) begin
        bit g;
        if (mon_on) begin
            if (bm_req && !prev_bm) chk(!core_ext_req, "R9 byte access began after core request", core_ext_req, 0);
            if (bm_req) run++;
            else if (run != 0) begin
                chk(run == cur_waits + 1, "R8 byte access length", run, cur_waits + 1);
                run = 0;
            end
            if (busy_o) chk(core_halt == cur_halt, "R11 core_halt while busy", core_halt, cur_halt);
            if (done_irq) irqs++;
            if (ctx_reset) begin
                ctxs++;
                chk(done_irq, "R11 ctx_reset without done_irq", done_irq, 1);
            end
            if (bm_req && bm_we) bwr[int'(bm_addr)] = bm_wdata;
        end
        prev_bm = bm_req;
        g = mem_req && (!gnt_noise || ($urandom_range(1, 0) == 1));
        if (mon_on && g) begin
            grants++;
            if (mem_we) begin
                chk(cnt_o == 14'(cur_n - words_seen), "R7 live count at word write", cnt_o, cur_n - words_seen);
                words_seen++;
                if (mem_pm) pm_wr[int'(mem_addr)] = mem_wdata;
                else        dm_wr[int'(mem_addr)] = mem_wdata;
            end
        end
        mem_gnt = g;
        core_ext_req = ext_noise && ($urandom_range(3, 0) == 0);
    end

    task automatic wr(input logic [2:0] s, input logic [13:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_xfer(input logic [1:0] f, input bit d, input bit h, input int ws,
                            input logic [21:0] xa, input logic [13:0] ia, input int n,
                            input bit noise, input bit poke);
        logic [3:0] ovl;
        int t, nb;
        nb = nbytes(f);
        ovl = 4'($urandom_range(15, 0));
        pm_wr.delete(); dm_wr.delete(); bwr.delete();
        run = 0; words_seen = 0; grants = 0; irqs = 0; ctxs = 0;
        cur_waits = ws; cur_n = n; cur_halt = h;
        ext_noise = noise; gnt_noise = noise; mon_on = 1;
        wr(3'd0, {2'b00, ovl, 4'(ws), h, d, f});
        wr(3'd1, {6'd0, xa[21:14]});
        wr(3'd2, xa[13:0]);
        wr(3'd3, ia);
        wr(3'd4, 14'(n));
        chk(busy_o, "R1 busy after nonzero count write", busy_o, 1);
        chk(cnt_o == 14'(n), "R7 count loaded", cnt_o, n);
        chk(mem_ovl == ovl, "R13 overlay pass-through", mem_ovl, ovl);
        if (poke) begin
            wr(3'd1, {6'd0, ~xa[21:14]});
            wr(3'd2, ~xa[13:0]);
            wr(3'd4, 14'd7);
            wr(3'd0, 14'h0FFF);
        end
        t = 0;
        while (irqs == 0 && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R7 transfer watchdog", t, 5000);
        repeat (2) @(negedge clk);
        mon_on = 0; ext_noise = 0; gnt_noise = 0;
        chk(irqs == 1, "R7 one completion pulse", irqs, 1);
        chk(ctxs == int'(h), "R11 context reset count", ctxs, h);
        chk(cnt_o == 0 && !busy_o, "R7 count zero and idle at end", cnt_o, 0);
        chk(!core_halt, "R11 core_halt released", core_halt, 0);
        chk(grants == n, "R10 one on-chip handshake per word", grants, n);
        chk(bm_addr == xa + 22'(n * nb), poke ? "R12 address after ignored writes" : "R2 final byte address",
            bm_addr, xa + 22'(n * nb));
        if (!d) begin
            chk(pm_wr.num() + dm_wr.num() == n, "R6 word writes in load", pm_wr.num() + dm_wr.num(), n);
            for (int k = 0; k < n; k++) begin
                logic [23:0] e, a;
                int idx;
                idx = int'(14'(ia + 14'(k)));
                e = exp_load(f, xa + 22'(k * nb));
                if (f == 2'b00) a = pm_wr.exists(idx) ? pm_wr[idx] : 24'hxxxxxx;
                else            a = dm_wr.exists(idx) ? dm_wr[idx] : 24'hxxxxxx;
                chk(a === e, ftag(f), a, e);
            end
        end else begin
            chk(bwr.num() == n * nb, "R6 byte writes in store", bwr.num(), n * nb);
            for (int k = 0; k < n; k++) begin
                for (int j = 0; j < nb; j++) begin
                    logic [7:0] e, a;
                    int idx;
                    idx = int'(xa + 22'(k * nb + j));
                    e = exp_store(f, gfun(14'(ia + 14'(k)), f == 2'b00), j);
                    a = bwr.exists(idx) ? bwr[idx] : 8'hxx;
                    chk(a === e, {"R6 store byte ", ftag(f)}, a, e);
                end
            end
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && cnt_o == 0, "R1 reset idle and count zero", {busy_o, cnt_o}, 0);
        chk(!bm_req && !mem_req && !done_irq && !core_halt && !ctx_reset, "R1 reset outputs quiet",
            {bm_req, mem_req, done_irq, core_halt, ctx_reset}, 0);
        wr(3'd4, 14'd0);
        repeat (4) @(negedge clk);
        chk(!busy_o && !bm_req && !mem_req, "R1 zero count write starts nothing", busy_o, 0);

        run_xfer(2'b00, 1'b0, 1'b0, 0,  {8'h05, 14'h3FFE}, 14'd10, 3, 1'b0, 1'b0); // R2 carry, R3
        run_xfer(2'b01, 1'b0, 1'b0, 15, 22'h012340, 14'd100, 2, 1'b0, 1'b0);     // R4, R8
        run_xfer(2'b10, 1'b0, 1'b0, 1,  22'h3FFFFF, 14'd200, 3, 1'b1, 1'b0);     // R5 high, wrap
        run_xfer(2'b11, 1'b0, 1'b1, 1,  22'h0A0000, 14'h3FFF, 3, 1'b1, 1'b0);    // R5 low, R11
        run_xfer(2'b00, 1'b1, 1'b1, 2,  22'h1FFFF0, 14'd7, 2, 1'b1, 1'b0);       // R6, R11
        run_xfer(2'b01, 1'b1, 1'b0, 0,  22'h000100, 14'd50, 3, 1'b0, 1'b0);      // R6
        run_xfer(2'b10, 1'b1, 1'b0, 3,  22'h222222, 14'd60, 2, 1'b1, 1'b0);      // R6
        run_xfer(2'b11, 1'b1, 1'b0, 0,  22'h333333, 14'd70, 4, 1'b0, 1'b0);      // R6
        run_xfer(2'b11, 1'b0, 1'b0, 2,  22'h044000, 14'd80, 4, 1'b0, 1'b1);      // R12

        for (int i = 0; i < 10; i++) begin
            run_xfer(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                     $urandom_range(15, 0), 22'($urandom), 14'($urandom), $urandom_range(6, 1),
                     1'($urandom_range(1, 0)), 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule